// File: doc/BRIEF.md
# Supply-Aware Power Mode Controller

This block sequences the operating mode of a system-basis controller. It has six modes: Reset, Normal Request, Normal, Standby, Stop and Sleep. It drives the regulator enable, an active-low reset to the host processor and a one-hot view of the current mode. Inputs arrive already synchronous and decoded. They are mode-write strobes, a chip-select line, a watchdog trigger with a window-violation flag, a wake event, and supply and thermal status. Two more status flags, no-stop and battery-fail, gate the fall into Sleep.

All dwell times are measured in ticks. A tick is `TICK_DIV` clock cycles. A single restartable duration timer covers the reset hold, the request window and the watchdog period. A second timer of the same kind measures how long the regulator has been undervoltage. When several exits hold in one cycle, a fixed ranking picks the winner.

Top module: `pmode_ctrl`

## Requirements
- R1: While `rst_n` is low the mode is Reset, `rst_out_n_o` is low and `reg_en_o` is high. `mode_oh_o` has bit 0 for Reset, bit 1 for Normal Request, bit 2 for Normal, bit 3 for Standby, bit 4 for Stop and bit 5 for Sleep.
- R2: Reset moves to Normal Request once `RESET_TICKS` ticks have elapsed. While `uv_i` is high in Reset, the hold timer stays cleared.
- R3: In Normal Request, a watchdog trigger moves the controller to Normal, and `rst_out_n_o` goes high.
- R4: A Standby write in Normal enters Standby. A Normal write in Standby enters Normal.
- R5: In Normal Request, Normal and Standby, the controller enters Reset on `uv_i`. In Normal and Standby it also enters Reset when `WD_TICKS` ticks pass with no trigger.
- R6: In Normal and Standby, a trigger with `wd_win_bad_i` high counts as a watchdog timeout and leads to Reset. In Stop the window flag is ignored and the trigger only restarts the timer.
- R7: A Stop write in Normal or Standby takes effect on the first later cycle where `cs_i` goes from low to high. An intervening Normal, Standby or Sleep write cancels it.
- R8: In Stop, a wake event moves the controller to Normal Request. `uv_i` or a watchdog expiry moves it to Reset.
- R9: From Normal or Standby, Sleep is entered only on two consecutive Sleep writes. Any other mode write or trigger between them cancels the first. `reg_en_o` is low only in Sleep.
- R10: In Sleep, a wake event moves the controller to Reset with `reg_en_o` high again. With no wake event it stays in Sleep.
- R11: When `REQ_TICKS` ticks pass in Normal Request without a trigger, the next mode depends on the flags. It is Sleep if both no-stop and battery-fail are low, and Reset otherwise.
- R12: Sleep is forced from any mode other than Sleep when no-stop and battery-fail are both low and either of two conditions holds. The conditions are `otemp_i` high, or `uv_i` held for `UV_TICKS` ticks while `sup_ok_i` is high.
- R13: Exits are ranked from highest to lowest:
  1. forced Sleep;
  2. undervoltage and watchdog faults;
  3. timer expiry, wake and trigger;
  4. commanded mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_normal_i | input | 1 | Decoded Normal mode write strobe |
| wr_standby_i | input | 1 | Decoded Standby mode write strobe |
| wr_stop_i | input | 1 | Decoded Stop mode write strobe |
| wr_sleep_i | input | 1 | Decoded Sleep mode write strobe |
| cs_i | input | 1 | Register-access chip select, high when idle |
| wd_trig_i | input | 1 | Watchdog trigger write strobe |
| wd_win_bad_i | input | 1 | Trigger fell outside the allowed window |
| wake_i | input | 1 | Wake-up event |
| uv_i | input | 1 | Regulator output below reset threshold |
| otemp_i | input | 1 | Regulator overtemperature |
| sup_ok_i | input | 1 | Supply above early-warning level |
| nostop_i | input | 1 | No-stop flag |
| batfail_i | input | 1 | Battery-fail flag |
| reg_en_o | output | 1 | Regulator enable |
| rst_out_n_o | output | 1 | Active-low reset to the host |
| mode_oh_o | output | 6 | One-hot current mode |

## Verification
Several pairs of exits can land in the same cycle:
- a fault and a command;
- overtemperature and undervoltage;
- a trigger and undervoltage in Normal Request.

The bench drives both stimuli in one cycle. It then checks the next mode against the R13 ranking: Reset beats Standby, forced Sleep beats Reset, and Reset beats Normal. A second race involves the chip-select edge and a cancelling write. A Stop write is followed by a Normal write before `cs_i` rises. The bench then confirms that the mode stays Normal.

// File: rtl/pmode_pkg.sv
package pmode_pkg;
   typedef enum logic [2:0] {
      PM_RST   = 3'd0,
      PM_NREQ  = 3'd1,
      PM_NORM  = 3'd2,
      PM_STBY  = 3'd3,
      PM_STOP  = 3'd4,
      PM_SLEEP = 3'd5
   } pm_mode_e;

   localparam int PM_NUM_MODES = 6;
endpackage

// File: rtl/pmode_timer.sv
module pmode_timer #(
   parameter int TICK_DIV = 4,
   parameter int CNT_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt_o
);
   logic tick;

   if (TICK_DIV < 1) begin : g_bad_div
      $error("pmode_timer: TICK_DIV must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_w
      $error("pmode_timer: CNT_W must be at least 2");
   end

   if (TICK_DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
   end else begin : g_div
      localparam int PRE_W = $clog2(TICK_DIV);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             pre_q <= '0;
         else if (clr)                           pre_q <= '0;
         else if (pre_q == PRE_W'(TICK_DIV - 1)) pre_q <= '0;
         else                                    pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PRE_W'(TICK_DIV - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_o <= '0;
      else if (clr)                cnt_o <= '0;
      else if (tick && cnt_o != '1) cnt_o <= cnt_o + 1'b1;
   end

   AST_TMR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && cnt_o == '1) |=> cnt_o == '1); // R2
endmodule

// File: rtl/pmode_cmd.sv
module pmode_cmd (
   input  logic clk,
   input  logic rst_n,
   input  logic allow,
   input  logic cs_i,
   input  logic wr_norm,
   input  logic wr_stby,
   input  logic wr_stop,
   input  logic wr_sleep,
   input  logic trig,
   output logic stop_go,
   output logic sleep_go
);
   logic cs_q, stop_pend_q, sleep_arm_q;

   assign stop_go  = allow && stop_pend_q && cs_i && !cs_q;
   assign sleep_go = allow && sleep_arm_q && wr_sleep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q        <= 1'b1;
         stop_pend_q <= 1'b0;
         sleep_arm_q <= 1'b0;
      end else begin
         cs_q <= cs_i;
         if (!allow || stop_go)                stop_pend_q <= 1'b0;
         else if (wr_stop)                     stop_pend_q <= 1'b1;
         else if (wr_norm || wr_stby || wr_sleep) stop_pend_q <= 1'b0;

         if (!allow)                           sleep_arm_q <= 1'b0;
         else if (wr_sleep)                    sleep_arm_q <= !sleep_arm_q;
         else if (wr_norm || wr_stby || wr_stop || trig) sleep_arm_q <= 1'b0;
      end
   end

   AST_SLEEP_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (allow && sleep_arm_q && (wr_norm || wr_stby || wr_stop || trig) && !wr_sleep)
      |=> !sleep_go || !sleep_arm_q); // R9
endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
   import pmode_pkg::*;
#(
   parameter int TICK_DIV    = 1000,
   parameter int RESET_TICKS = 34,
   parameter int REQ_TICKS   = 3500,
   parameter int WD_TICKS    = 3500,
   parameter int UV_TICKS    = 1000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_normal_i,
   input  logic                    wr_standby_i,
   input  logic                    wr_stop_i,
   input  logic                    wr_sleep_i,
   input  logic                    cs_i,
   input  logic                    wd_trig_i,
   input  logic                    wd_win_bad_i,
   input  logic                    wake_i,
   input  logic                    uv_i,
   input  logic                    otemp_i,
   input  logic                    sup_ok_i,
   input  logic                    nostop_i,
   input  logic                    batfail_i,
   output logic                    reg_en_o,
   output logic                    rst_out_n_o,
   output logic [PM_NUM_MODES-1:0] mode_oh_o
);
   localparam int MAX_A   = (RESET_TICKS > REQ_TICKS) ? RESET_TICKS : REQ_TICKS;
   localparam int MAX_B   = (WD_TICKS > UV_TICKS) ? WD_TICKS : UV_TICKS;
   localparam int MAX_LIM = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W   = $clog2(MAX_LIM + 1) + 1;

   if (RESET_TICKS < 1 || REQ_TICKS < 1 || WD_TICKS < 1 || UV_TICKS < 1) begin : g_bad_lim
      $error("pmode_ctrl: every duration must be at least one tick");
   end

   pm_mode_e         st_q, st_d;
   logic [CNT_W-1:0] tmr_cnt, uv_cnt, lim;
   logic             tmr_clr, uv_clr, allow, stop_go, sleep_go;
   logic             flags_ok, uv_long, force_sl, expired, wd_fault, watched;

   assign allow    = (st_q == PM_NORM) || (st_q == PM_STBY);
   assign watched  = allow || (st_q == PM_STOP);
   assign flags_ok = !nostop_i && !batfail_i;
   assign uv_long  = uv_cnt >= CNT_W'(UV_TICKS);
   assign force_sl = flags_ok && (otemp_i || (uv_long && sup_ok_i));

   always_comb begin
      case (st_q)
         PM_RST:  lim = CNT_W'(RESET_TICKS);
         PM_NREQ: lim = CNT_W'(REQ_TICKS);
         default: lim = CNT_W'(WD_TICKS);
      endcase
   end
   assign expired  = tmr_cnt >= lim;
   assign wd_fault = expired || (wd_trig_i && wd_win_bad_i);

   always_comb begin
      st_d = st_q;
      case (st_q)
         PM_RST: begin
            if (force_sl)                 st_d = PM_SLEEP;
            else if (!uv_i && expired)    st_d = PM_NREQ;
         end
         PM_NREQ: begin
            if (force_sl)                 st_d = PM_SLEEP;
            else if (uv_i)                st_d = PM_RST;
            else if (expired)             st_d = flags_ok ? PM_SLEEP : PM_RST;
            else if (wd_trig_i)           st_d = PM_NORM;
         end
         PM_NORM, PM_STBY: begin
            if (force_sl)                 st_d = PM_SLEEP;
            else if (uv_i || wd_fault)    st_d = PM_RST;
            else if (sleep_go)            st_d = PM_SLEEP;
            else if (stop_go)             st_d = PM_STOP;
            else if (st_q == PM_STBY && wr_normal_i)  st_d = PM_NORM;
            else if (st_q == PM_NORM && wr_standby_i) st_d = PM_STBY;
         end
         PM_STOP: begin
            if (force_sl)                 st_d = PM_SLEEP;
            else if (uv_i || expired)     st_d = PM_RST;
            else if (wake_i)              st_d = PM_NREQ;
         end
         PM_SLEEP: begin
            if (wake_i)                   st_d = PM_RST;
         end
         default:                         st_d = PM_RST;
      endcase
   end

   assign tmr_clr = (st_d != st_q) || (st_q == PM_RST && uv_i) || (watched && wd_trig_i);
   assign uv_clr  = !uv_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= PM_RST;
      else        st_q <= st_d;
   end

   pmode_timer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_dur_tmr (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .cnt_o(tmr_cnt));

   pmode_timer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_uv_tmr (
      .clk(clk), .rst_n(rst_n), .clr(uv_clr), .cnt_o(uv_cnt));

   pmode_cmd u_cmd (
      .clk(clk), .rst_n(rst_n), .allow(allow), .cs_i(cs_i),
      .wr_norm(wr_normal_i), .wr_stby(wr_standby_i), .wr_stop(wr_stop_i),
      .wr_sleep(wr_sleep_i), .trig(wd_trig_i),
      .stop_go(stop_go), .sleep_go(sleep_go));

   assign reg_en_o    = (st_q != PM_SLEEP);
   assign rst_out_n_o = (st_q != PM_RST);
   assign mode_oh_o   = PM_NUM_MODES'(1) << st_q;

   AST_UV_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_i && !force_sl && (watched || st_q == PM_NREQ)) |=> st_q == PM_RST); // R5
   AST_STOP_ON_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PM_STOP && $past(st_q) != PM_STOP) |-> ($past(cs_i) && !$past(cs_i, 2))); // R7
   AST_TRIG_TO_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PM_NREQ && wd_trig_i && !uv_i && !force_sl && !expired) |=> st_q == PM_NORM); // R3
   AST_AUTO_SLEEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PM_SLEEP && $past(st_q) != PM_SLEEP && $past(st_q) != PM_NORM
       && $past(st_q) != PM_STBY) |-> $past(!nostop_i && !batfail_i)); // R12
   AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PM_SLEEP && wake_i) |=> (st_q == PM_RST && reg_en_o)); // R10
endmodule

// File: tb/tb_pmode_ctrl.sv
`timescale 1ns/1ps
module tb_pmode_ctrl;
   localparam logic [5:0] M_RST = 6'b000001, M_NREQ = 6'b000010, M_NORM = 6'b000100,
                          M_STBY = 6'b001000, M_STOP = 6'b010000, M_SLEEP = 6'b100000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_normal_i = 0, wr_standby_i = 0, wr_stop_i = 0, wr_sleep_i = 0, cs_i = 1'b0;
   logic wd_trig_i = 0, wd_win_bad_i = 0, wake_i = 0, uv_i = 0, otemp_i = 0;
   logic sup_ok_i = 0, nostop_i = 1'b1, batfail_i = 0;
   logic reg_en_o, rst_out_n_o;
   logic [5:0] mode_oh_o;
   int vectors = 0, errs = 0;
   bit done = 0;

   always #2 clk = ~clk;

   pmode_ctrl #(.TICK_DIV(2), .RESET_TICKS(3), .REQ_TICKS(5), .WD_TICKS(6), .UV_TICKS(4)) dut (
      .clk(clk), .rst_n(rst_n), .wr_normal_i(wr_normal_i), .wr_standby_i(wr_standby_i),
      .wr_stop_i(wr_stop_i), .wr_sleep_i(wr_sleep_i), .cs_i(cs_i), .wd_trig_i(wd_trig_i),
      .wd_win_bad_i(wd_win_bad_i), .wake_i(wake_i), .uv_i(uv_i), .otemp_i(otemp_i),
      .sup_ok_i(sup_ok_i), .nostop_i(nostop_i), .batfail_i(batfail_i),
      .reg_en_o(reg_en_o), .rst_out_n_o(rst_out_n_o), .mode_oh_o(mode_oh_o));

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk_mode(string req, logic [5:0] exp);
      vectors++;
      if (mode_oh_o !== exp) begin
         errs++;
         $display("FAIL %s mode=%b expected=%b", req, mode_oh_o, exp);
      end
   endtask

   task automatic chk_bit(string req, string what, logic act, logic exp);
      vectors++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s=%b expected=%b", req, what, act, exp);
      end
   endtask

   // one-cycle strobe: 0 normal,1 standby,2 stop,3 sleep,4 trig,5 bad trig,6 wake
   task automatic pulse(int which);
      case (which)
         0: wr_normal_i = 1;  1: wr_standby_i = 1;  2: wr_stop_i = 1;  3: wr_sleep_i = 1;
         4: wd_trig_i = 1;    5: begin wd_trig_i = 1; wd_win_bad_i = 1; end
         default: wake_i = 1;
      endcase
      step(1);
      {wr_normal_i, wr_standby_i, wr_stop_i, wr_sleep_i, wd_trig_i, wd_win_bad_i, wake_i} = '0;
   endtask

   task automatic to_normal();
      rst_n = 0; step(2); rst_n = 1;
      step(7);
      chk_mode("R2 boot", M_NREQ);
      pulse(4);
      chk_mode("R3 boot", M_NORM);
   endtask

   task automatic t_reset();
      rst_n = 0; step(2);
      chk_mode("R1", M_RST);
      chk_bit("R1", "rst_out_n", rst_out_n_o, 1'b0);
      chk_bit("R1", "reg_en", reg_en_o, 1'b1);
      rst_n = 1; step(6);
      chk_mode("R2 hold", M_RST);
      step(1);
      chk_mode("R2 expiry", M_NREQ);
      pulse(4);
      chk_mode("R3", M_NORM);
      chk_bit("R3", "rst_out_n", rst_out_n_o, 1'b1);
      // undervoltage holds Reset
      rst_n = 0; step(2); uv_i = 1; rst_n = 1; step(20);
      chk_mode("R2 uv hold", M_RST);
      uv_i = 0; step(7);
      chk_mode("R2 after uv", M_NREQ);
   endtask

   task automatic t_modes();
      to_normal();
      pulse(1); chk_mode("R4 to standby", M_STBY);
      pulse(0); chk_mode("R4 to normal", M_NORM);
   endtask

   task automatic t_watchdog();
      to_normal();
      step(11); chk_mode("R5 wd not yet", M_NORM);
      step(2);  chk_mode("R5 wd expiry", M_RST);
      to_normal();
      uv_i = 1; step(1); uv_i = 0;
      chk_mode("R5 uv", M_RST);
      to_normal();
      pulse(5); chk_mode("R6 window", M_RST);
   endtask

   task automatic t_stop();
      to_normal();
      pulse(2); step(2); chk_mode("R7 wait cs", M_NORM);
      cs_i = 1; step(1); chk_mode("R7 cs rise", M_STOP);
      cs_i = 0;
      pulse(5); step(1); chk_mode("R6 stop ignores window", M_STOP);
      pulse(6); chk_mode("R8 wake", M_NREQ);
      pulse(4); chk_mode("R8 back normal", M_NORM);
      pulse(2); pulse(0); cs_i = 1; step(1); cs_i = 0;
      chk_mode("R7 cancelled", M_NORM);
      pulse(2); cs_i = 1; step(1); cs_i = 0;
      chk_mode("R7 stop again", M_STOP);
      uv_i = 1; step(1); uv_i = 0;
      chk_mode("R8 uv in stop", M_RST);
   endtask

   task automatic t_sleep();
      to_normal();
      pulse(3); pulse(0); pulse(3);
      chk_mode("R9 interrupted", M_NORM);
      pulse(1); chk_mode("R9 cancel write", M_STBY);
      pulse(3); pulse(3);
      chk_mode("R9 sleep", M_SLEEP);
      chk_bit("R9", "reg_en", reg_en_o, 1'b0);
      step(20); chk_mode("R10 stays", M_SLEEP);
      pulse(6);
      chk_mode("R10 wake", M_RST);
      chk_bit("R10", "reg_en", reg_en_o, 1'b1);
   endtask

   task automatic t_req_expiry();
      nostop_i = 1; rst_n = 0; step(2); rst_n = 1; step(7);
      step(10); chk_mode("R11 not yet", M_NREQ);
      step(1);  chk_mode("R11 nostop", M_RST);
      nostop_i = 0; batfail_i = 1; step(7 + 11);
      chk_mode("R11 batfail", M_RST);
      batfail_i = 0; step(7 + 11);
      chk_mode("R11 sleep", M_SLEEP);
      nostop_i = 1; pulse(6);
   endtask

   task automatic t_force();
      nostop_i = 1; to_normal();
      otemp_i = 1; step(2); chk_mode("R12 nostop blocks", M_NORM);
      nostop_i = 0; step(1); chk_mode("R12 otemp", M_SLEEP);
      otemp_i = 0; nostop_i = 1; pulse(6);
      to_normal();
      nostop_i = 0; sup_ok_i = 1; uv_i = 1; step(1);
      chk_mode("R5 uv first", M_RST);
      step(9); chk_mode("R12 uv long", M_SLEEP);
      uv_i = 0; nostop_i = 1; pulse(6);
      to_normal();
      nostop_i = 0; sup_ok_i = 0; uv_i = 1; step(20);
      chk_mode("R12 low supply", M_RST);
      uv_i = 0; nostop_i = 1;
   endtask

   task automatic t_priority();
      to_normal();
      uv_i = 1; wr_standby_i = 1; step(1); uv_i = 0; wr_standby_i = 0;
      chk_mode("R13 uv over cmd", M_RST);
      to_normal();
      nostop_i = 0; otemp_i = 1; uv_i = 1; step(1); otemp_i = 0; uv_i = 0;
      chk_mode("R13 force over uv", M_SLEEP);
      nostop_i = 1; pulse(6);
      rst_n = 0; step(2); rst_n = 1; step(7);
      uv_i = 1; wd_trig_i = 1; step(1); uv_i = 0; wd_trig_i = 0;
      chk_mode("R13 uv over trig", M_RST);
   endtask

   initial begin
      t_reset();
      t_modes();
      t_watchdog();
      t_stop();
      t_sleep();
      t_req_expiry();
      t_force();
      t_priority();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL watchdog run=%0d expected=done", vectors);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
         $finish;
      end
   end
endmodule